// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the two least significant address bits of a four-beat burst in a synchronous burst memory. When the address-strobe logic captures a new external address, it raises a load strobe. The sequencer then copies the two low external address bits in as the starting offset. After that, each clock edge on which the active-low advance input is low moves the burst to its next beat.

A static strap selects the beat order. One order counts up and wraps inside the aligned group of four words. The other forms the offset as the XOR of the starting offset and the beat count. The upper address bits and the memory array sit outside this block.

Inside, a small state machine has two states. `ST_IDLE` means no address has been loaded since reset. `ST_BURST` means a burst is in progress. It has three named transitions:
- `T_LOAD`: any state to `ST_BURST` when the load strobe is high.
- `T_STEP`: `ST_BURST` to `ST_BURST` with the beat count incremented, when advance is low and there is no load.
- `T_HOLD`: any state to itself with nothing changed.

In `ST_IDLE` an advance without a load takes `T_HOLD`. The beat count is a modulo-4 register. A combinational mapper turns the stored start offset and the beat count into the output offset.

Top module: `burst_offset_seq`

## Requirements
- R1: While reset (`rst_n` low) is applied and in the first cycle after it, the offset output is 0 and no burst is active.
- R2: On a clock edge where `load` is 1, the offset after that edge equals the `addr_lo` value sampled at the edge, and the beat count restarts at zero.
- R3: When `load` is 1 and `adv_n` is 0 at the same edge, the load takes effect and the advance is discarded: the offset equals the new `addr_lo`.
- R4: With `mode` = 0 (linear), each edge with `adv_n` = 0 and `load` = 0 gives offset = (start + k) mod 4, where k is the number of advances since the load.
- R5: With `mode` = 1 (interleaved, the strap's pulled-up level), the offset is start XOR (k mod 4).
- R6: An edge with `adv_n` = 1 and `load` = 0 leaves the offset unchanged.
- R7: After the fourth beat, further advances keep wrapping inside the same aligned four-word group, so the fifth beat equals the start offset.
- R8: Before any load since reset, `adv_n` = 0 has no effect and the offset stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_lo | input | 2 | Low external address bits used as the burst start |
| load | input | 1 | High when a new external address is being captured |
| adv_n | input | 1 | Active-low advance; steps the burst by one beat |
| mode | input | 1 | Static order strap: 0 linear, 1 interleaved |
| ofs | output | 2 | Current burst offset |

## Verification
The hardest situation to reach is a load and an advance at the same edge in the middle of a running burst. It needs a burst already partway along, so that a discarded advance would leave a visibly different offset. The vector table first steps a burst in each order and then issues the colliding load with a different start address. The second hard case is an advance before any load. The bench reaches it only by applying reset and then advancing before it loads anything.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

    typedef enum logic [1:0] {
        T_HOLD = 2'd0,
        T_LOAD = 2'd1,
        T_STEP = 2'd2
    } seq_trans_t;
endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
#(
    parameter int W = OFS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv_n,
    input  logic [W-1:0] start_in,
    output logic [W-1:0] start_q,
    output logic [W-1:0] beat_q,
    output logic         active
);
    seq_state_t state_q, state_d;
    seq_trans_t trans;
    logic [W-1:0] beat_d, start_d;

    // Transition selection: load has priority over advance.
    always_comb begin
        if (load)
            trans = T_LOAD;
        else if (!adv_n && state_q == ST_BURST)
            trans = T_STEP;
        else
            trans = T_HOLD;
    end

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        start_d = start_q;
        unique case (trans)
            T_LOAD: begin
                state_d = ST_BURST;
                beat_d  = '0;
                start_d = start_in;
            end
            T_STEP: begin
                beat_d = beat_q + W'(1);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            start_q <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            start_q <= start_d;
        end
    end

    assign active = (state_q == ST_BURST);

    a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0) && active);
    a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && active) |=> beat_q == $past(beat_q) + W'(1));
    a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> $stable(beat_q) && $stable(start_q));
    a_r8_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load) |=> !active && beat_q == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int W = OFS_W
) (
    input  logic [W-1:0] start,
    input  logic [W-1:0] beat,
    input  logic         interleave,
    output logic [W-1:0] ofs
);
    logic [W-1:0] lin_ofs, xor_ofs;

    // Linear order wraps inside the aligned group by dropping the carry.
    assign lin_ofs = start + beat;
    assign xor_ofs = start ^ beat;
    assign ofs     = interleave ? xor_ofs : lin_ofs;

    always_comb begin
        if (beat == '0) begin
            a_r2_first_beat: assert (ofs == start);
        end
    end
endmodule

// File: rtl/burst_offset_seq.sv
module burst_offset_seq
    import burst_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OFS_W-1:0] addr_lo,
    input  logic            load,
    input  logic            adv_n,
    input  logic            mode,
    output logic [OFS_W-1:0] ofs
);
    logic [OFS_W-1:0] start_q, beat_q;
    logic             active;

    burst_beat_fsm #(.W(OFS_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv_n    (adv_n),
        .start_in (addr_lo),
        .start_q  (start_q),
        .beat_q   (beat_q),
        .active   (active)
    );

    burst_order_map #(.W(OFS_W)) u_map (
        .start      (start_q),
        .beat       (beat_q),
        .interleave (mode),
        .ofs        (ofs)
    );

    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ofs == $past(addr_lo));
    a_r7_same_group: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && active && beat_q == OFS_W'(BEATS-1)) |=> ofs == start_q);
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> ofs == '0);
endmodule

// File: tb/sim_burst_offset_seq.sv
module sim_burst_offset_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr_lo = '0;
    logic       load = 1'b0;
    logic       adv_n = 1'b1;
    logic       mode = 1'b0;
    logic [1:0] ofs;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_offset_seq u0 (
        .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .load(load),
        .adv_n(adv_n), .mode(mode), .ofs(ofs)
    );

    // Vector: [10:7] requirement, [6] mode, [5] load, [4] adv_n, [3:2] addr, [1:0] expected
    localparam int NV = 16;
    localparam logic [10:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b1, 1'b1, 2'd2, 2'd2}, // R2 load start 2, linear
        {4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3}, // R4
        {4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R4 wrap in group
        {4'd6, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0}, // R6 hold
        {4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1}, // R4 fourth beat
        {4'd7, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2}, // R7 fifth beat = start
        {4'd3, 1'b0, 1'b1, 1'b0, 2'd1, 2'd1}, // R3 load beats advance
        {4'd4, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2}, // R4
        {4'd2, 1'b1, 1'b1, 1'b1, 2'd1, 2'd1}, // R2 load start 1, interleaved
        {4'd5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0}, // R5 1^1
        {4'd5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd3}, // R5 1^2
        {4'd5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2}, // R5 1^3
        {4'd7, 1'b1, 1'b0, 1'b0, 2'd0, 2'd1}, // R7 wraps to start
        {4'd3, 1'b1, 1'b1, 1'b0, 2'd3, 2'd3}, // R3 load mid-burst
        {4'd5, 1'b1, 1'b0, 1'b0, 2'd0, 2'd2}, // R5 3^1
        {4'd6, 1'b1, 1'b0, 1'b1, 2'd2, 2'd2}  // R6 hold, addr ignored
    };

    task automatic check(input string req, input logic [1:0] exp);
        checks++;
        if (ofs !== exp) begin
            errors++;
            $display("FAIL %s: ofs=%0d expected=%0d", req, ofs, exp);
        end
    endtask

    // Drive after a falling edge, sample at the following falling edge.
    task automatic step(input logic m, input logic ld, input logic av, input logic [1:0] a);
        mode = m; load = ld; adv_n = av; addr_lo = a;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1", 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 2'd0);
        // R8: advance with no load since reset
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 1'b0, 2'd3);
            check("R8", 2'd0);
        end
        step(1'b1, 1'b0, 1'b0, 2'd2);
        check("R8", 2'd0);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:2]);
            check($sformatf("R%0d", VEC[i][10:7]), VEC[i][1:0]);
        end
        // R1: reset mid-burst returns to zero and idle
        step(1'b0, 1'b1, 1'b1, 2'd3);
        check("R2", 2'd3);
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b1, 2'd0);
        check("R1", 2'd0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 2'd0);
        check("R8", 2'd0);
        // R7: long linear run from start 3 stays in the group
        step(1'b0, 1'b1, 1'b1, 2'd3);
        for (int k = 1; k <= 9; k++) begin
            step(1'b0, 1'b0, 1'b0, 2'd0);
            check("R7", 2'((3 + k) % 4));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: ofs=%0d expected=finish", ofs);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule